// File: doc/BRIEF.md
# Read-Only Identity Region Reader

This block serves the read-only identity area of a serial memory. The area holds a 16-byte unique serial number and an extended identifier of either 6 bytes (48-bit mode) or 8 bytes (64-bit mode). The identifier starts with a 3-byte organization prefix, and the rest of it is the extension. All of these contents are fixed by parameters, and a parameter selects the identifier width.

A bus engine owns the byte address pointer, which it shares with the main array. For each byte it wants to read, it presents the pointer and pulses a read request. One cycle later the block returns the addressed byte and the next pointer value. The engine writes that value back so that later reads, including current-address reads of the main array, continue from it. The address map is sparse, so the block also reports addresses whose data is undefined. A write attempt into the area is refused and changes nothing.

Top module: `idr_reader`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are zero after that edge.
- R2: A cycle with `rd_req` high makes `rd_valid` high for exactly the next cycle. A cycle without it makes `rd_valid` low in the next cycle.
- R3: Pointer values 80h+k (k = 0..15) return serial byte k, where byte 0 is the most significant byte of the 128-bit serial parameter. `rd_undef` is 0 for these reads.
- R4: In 64-bit mode, pointers 98h..9Fh return the 3 prefix bytes and then the 5 extension bytes, each most significant byte first.
- R5: In 48-bit mode, pointers 9Ah..9Fh return the 3 prefix bytes and then the low 3 bytes of the extension parameter, most significant first. Pointers 98h and 99h are undefined in this mode.
- R6: Any pointer outside the defined serial and identifier ranges returns FFh with `rd_undef` high. A defined read has `rd_undef` low, and `rd_undef` is never high without `rd_valid`.
- R7: `ptr_next` is the read pointer plus one, modulo 256, except after 9Fh, where it is 80h.
- R8: A `wr_req` makes `wr_refused` high for exactly the next cycle. It gives no `rd_valid`, leaves `ptr_next` unchanged, and a later read of the same pointer returns the same byte.
- R9: In 64-bit mode, if the top 16 extension bits are FFFEh or FFFFh, every identifier pointer reads as undefined (FFh, `rd_undef` high). Serial reads are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read one byte at `ptr_in` |
| wr_req | input | 1 | Write attempt into the area |
| ptr_in | input | 8 | Current shared byte pointer |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 8 | Byte read |
| rd_undef | output | 1 | Read address has undefined data |
| ptr_next | output | 8 | Pointer value to store after the read |
| wr_refused | output | 1 | Write attempt refused |

## Verification
The assertions take for granted that `ptr_in` is a known value in every cycle where `rd_req` is high, and that both request inputs are known from the first reset edge onward. The bench drives every input on the falling clock edge, holds reset over the first edges, and keeps each request to a single cycle with a stable pointer. It samples the registered response on the following falling edge. Three instances cover the 64-bit, 48-bit and reserved-extension variants, and all three receive the same stimulus.

// File: rtl/idr_pkg.sv
package idr_pkg;

    localparam int ADDR_W   = 8;
    localparam int BYTE_W   = 8;
    localparam int SN_BYTES = 16;
    localparam int ID_MAX   = 8;

    localparam logic [ADDR_W-1:0] ID_LAST   = 8'h9F;
    localparam logic [ADDR_W-1:0] WRAP_BASE = 8'h80;
    localparam logic [3:0]        SN_NIB    = 4'h8;
    localparam logic [3:0]        ID_NIB    = 4'h9;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        RG_NONE   = 2'd0,
        RG_SERIAL = 2'd1,
        RG_IDENT  = 2'd2
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [3:0] offset;
    } decode_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              undef;
        logic [ADDR_W-1:0] next;
    } resp_t;

    // Low nibble of the first identifier byte for a given width.
    function automatic logic [3:0] id_first_nib(input bit wide);
        return wide ? 4'h8 : 4'hA;
    endfunction

    // Extension values FFFEh/FFFFh at the top mark an encapsulated 48-bit value.
    function automatic bit ext_reserved(input logic [39:0] ext);
        return ext[39:25] == 15'h7FFF;
    endfunction

    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] a);
        return (a == ID_LAST) ? WRAP_BASE : a + 8'd1;
    endfunction

endpackage

// File: rtl/idr_decode.sv
module idr_decode
    import idr_pkg::*;
#(
    parameter bit ID_WIDE = 1'b1,
    parameter bit ID_OK   = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam logic [3:0] FIRST = id_first_nib(ID_WIDE);

    always_comb begin
        dec.region = RG_NONE;
        dec.offset = 4'h0;
        if (addr[7:4] == SN_NIB) begin
            dec.region = RG_SERIAL;
            dec.offset = addr[3:0];
        end else if (ID_OK && addr[7:4] == ID_NIB && addr[3:0] >= FIRST) begin
            dec.region = RG_IDENT;
            dec.offset = addr[3:0] - FIRST;
        end
    end
endmodule

// File: rtl/idr_rom.sv
module idr_rom
    import idr_pkg::*;
#(
    parameter bit           ID_WIDE    = 1'b1,
    parameter logic [127:0] SERIAL_NUM = '0,
    parameter logic [23:0]  ID_PREFIX  = '0,
    parameter logic [39:0]  ID_EXT     = '0
) (
    input  decode_t           dec,
    output logic [BYTE_W-1:0] byte_o,
    output logic              undef_o
);
    logic [BYTE_W-1:0] sn_b [SN_BYTES];
    logic [BYTE_W-1:0] id_b [ID_MAX];

    for (genvar k = 0; k < SN_BYTES; k++) begin : g_sn
        assign sn_b[k] = SERIAL_NUM[127 - 8*k -: 8];
    end

    if (ID_WIDE) begin : g_id64
        localparam logic [63:0] IMG = {ID_PREFIX, ID_EXT};
        for (genvar k = 0; k < ID_MAX; k++) begin : g_b
            assign id_b[k] = IMG[63 - 8*k -: 8];
        end
    end else begin : g_id48
        localparam logic [63:0] IMG = {ID_PREFIX, ID_EXT[23:0], 16'hFFFF};
        for (genvar k = 0; k < ID_MAX; k++) begin : g_b
            assign id_b[k] = IMG[63 - 8*k -: 8];
        end
    end

    always_comb begin
        unique case (dec.region)
            RG_SERIAL: begin
                byte_o  = sn_b[dec.offset];
                undef_o = 1'b0;
            end
            RG_IDENT: begin
                byte_o  = id_b[dec.offset[2:0]];
                undef_o = 1'b0;
            end
            default: begin
                byte_o  = FILL_BYTE;
                undef_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/idr_reader.sv
module idr_reader
    import idr_pkg::*;
#(
    parameter bit           ID_WIDE    = 1'b1,
    parameter logic [127:0] SERIAL_NUM = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF,
    parameter logic [23:0]  ID_PREFIX  = 24'h00_50_C2,
    parameter logic [39:0]  ID_EXT     = 40'h01_23_45_67_89
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_req,
    input  logic        wr_req,
    input  logic [7:0]  ptr_in,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        rd_undef,
    output logic [7:0]  ptr_next,
    output logic        wr_refused
);
    localparam bit ID_OK = !(ID_WIDE && ext_reserved(ID_EXT));

    decode_t           dec;
    logic [BYTE_W-1:0] rom_byte;
    logic              rom_undef;
    resp_t             resp_q;
    logic              wr_q;

    idr_decode #(.ID_WIDE(ID_WIDE), .ID_OK(ID_OK)) decode_i (
        .addr (ptr_in),
        .dec  (dec)
    );

    idr_rom #(
        .ID_WIDE    (ID_WIDE),
        .SERIAL_NUM (SERIAL_NUM),
        .ID_PREFIX  (ID_PREFIX),
        .ID_EXT     (ID_EXT)
    ) rom_i (
        .dec     (dec),
        .byte_o  (rom_byte),
        .undef_o (rom_undef)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
            wr_q   <= 1'b0;
        end else begin
            wr_q         <= wr_req;
            resp_q.valid <= rd_req;
            resp_q.undef <= rd_req & rom_undef;
            if (rd_req) begin
                resp_q.data <= rom_byte;
                resp_q.next <= step_ptr(ptr_in);
            end
        end
    end

    assign rd_valid   = resp_q.valid;
    assign rd_data    = resp_q.data;
    assign rd_undef   = resp_q.undef;
    assign ptr_next   = resp_q.next;
    assign wr_refused = wr_q;
endmodule

// File: rtl/idr_reader_chk.sv
module idr_reader_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_req,
    input logic       wr_req,
    input logic [7:0] ptr_in,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       rd_undef,
    input logic [7:0] ptr_next,
    input logic       wr_refused
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!rd_valid && !rd_undef && !wr_refused && rd_data == 8'h00 && ptr_next == 8'h00));

    p_read_valid_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    p_serial_defined_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ptr_in[7:4] == 4'h8) |=> !rd_undef);

    p_undef_fill_r6: assert property (@(posedge clk) disable iff (rst)
        rd_undef |-> (rd_valid && rd_data == 8'hFF));

    p_low_half_undef_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !ptr_in[7]) |=> rd_undef);

    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ptr_in == 8'h9F) |=> ptr_next == 8'h80);

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ptr_in != 8'h9F) |=> ptr_next == $past(ptr_in) + 8'd1);

    p_write_refused_r8: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> wr_refused);

    p_write_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> !wr_refused);

    p_write_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !rd_req) |=> $stable(ptr_next));
endmodule

bind idr_reader idr_reader_chk chk_i (.*);

// File: tb/idr_reader_tb_top.sv
module idr_reader_tb_top;
    localparam logic [127:0] SN   = 128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF00;
    localparam logic [23:0]  PFX  = 24'hA1B2C3;
    localparam logic [39:0]  EXT  = 40'h12_3456_7890;
    localparam logic [39:0]  EXTB = 40'hFF_FE00_0001;

    // {addr, data, undef, next} for the 64-bit instance.
    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        32'h80_11_00_81, 32'h85_66_00_86, 32'h8F_00_00_90, 32'h90_FF_01_91,
        32'h97_FF_01_98, 32'h98_A1_00_99, 32'h9A_C3_00_9B, 32'h9B_12_00_9C,
        32'h9F_90_00_80, 32'h00_FF_01_01, 32'h7F_FF_01_80, 32'hA0_FF_01_A1,
        32'hFF_FF_01_00
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_req = 1'b0;
    logic wr_req = 1'b0;
    logic [7:0] ptr_in = 8'h00;

    logic       v64, u64, w64, v48, u48, w48, vbd, ubd, wbd;
    logic [7:0] d64, n64, d48, n48, dbd, nbd;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    idr_reader #(.ID_WIDE(1'b1), .SERIAL_NUM(SN), .ID_PREFIX(PFX), .ID_EXT(EXT)) dut_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .ptr_in(ptr_in),
        .rd_valid(v64), .rd_data(d64), .rd_undef(u64), .ptr_next(n64), .wr_refused(w64));

    idr_reader #(.ID_WIDE(1'b0), .SERIAL_NUM(SN), .ID_PREFIX(PFX), .ID_EXT(EXT)) dut48_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .ptr_in(ptr_in),
        .rd_valid(v48), .rd_data(d48), .rd_undef(u48), .ptr_next(n48), .wr_refused(w48));

    idr_reader #(.ID_WIDE(1'b1), .SERIAL_NUM(SN), .ID_PREFIX(PFX), .ID_EXT(EXTB)) dutbd_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .ptr_in(ptr_in),
        .rd_valid(vbd), .rd_data(dbd), .rd_undef(ubd), .ptr_next(nbd), .wr_refused(wbd));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one request on a falling edge, sample after the next rising edge.
    task automatic issue(input logic rd, input logic wr, input logic [7:0] a);
        rd_req = rd;
        wr_req = wr;
        ptr_in = a;
        @(negedge clk);
        rd_req = 1'b0;
        wr_req = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] walk;
        logic [7:0] keep_next;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", {31'd0, v64}, 32'd0);
        chk("R1 data/next", {16'd0, d64, n64}, 32'd0);
        chk("R1 flags", {30'd0, u64, w64}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        // R2: idle gives no response
        chk("R2 idle", {31'd0, v64}, 32'd0);

        // R3 R4 R6 R7: table walk on the 64-bit instance
        for (int i = 0; i < NV; i++) begin
            issue(1'b1, 1'b0, VEC[i][31:24]);
            chk("R2 valid", {31'd0, v64}, 32'd1);
            chk("R3/R4 data", {24'd0, d64}, {24'd0, VEC[i][23:16]});
            chk("R6 undef", {31'd0, u64}, {31'd0, VEC[i][8]});
            chk("R7 next", {24'd0, n64}, {24'd0, VEC[i][7:0]});
        end
        @(negedge clk);
        chk("R2 single pulse", {31'd0, v64}, 32'd0);
        chk("R6 undef needs valid", {31'd0, u64}, 32'd0);

        // R5: 48-bit map
        issue(1'b1, 1'b0, 8'h98);
        chk("R5 98 undef", {23'd0, u48, d48}, 32'h1FF);
        issue(1'b1, 1'b0, 8'h99);
        chk("R5 99 undef", {23'd0, u48, d48}, 32'h1FF);
        issue(1'b1, 1'b0, 8'h9A);
        chk("R5 9A prefix", {23'd0, u48, d48}, 32'h0A1);
        issue(1'b1, 1'b0, 8'h9D);
        chk("R5 9D ext", {23'd0, u48, d48}, 32'h056);
        issue(1'b1, 1'b0, 8'h9F);
        chk("R5 9F ext", {23'd0, u48, d48}, 32'h090);
        chk("R7 48 wrap", {24'd0, n48}, 32'h80);

        // R9: reserved extension disables identifier
        issue(1'b1, 1'b0, 8'h98);
        chk("R9 98", {23'd0, ubd, dbd}, 32'h1FF);
        issue(1'b1, 1'b0, 8'h9C);
        chk("R9 9C", {23'd0, ubd, dbd}, 32'h1FF);
        issue(1'b1, 1'b0, 8'h81);
        chk("R9 serial intact", {23'd0, ubd, dbd}, 32'h022);

        // R8: write refused, no effect
        issue(1'b1, 1'b0, 8'h9A);
        keep_next = n64;
        issue(1'b0, 1'b1, 8'h9A);
        chk("R8 refused", {31'd0, w64}, 32'd1);
        chk("R8 no valid", {31'd0, v64}, 32'd0);
        chk("R8 next held", {24'd0, n64}, {24'd0, keep_next});
        @(negedge clk);
        chk("R8 single pulse", {31'd0, w64}, 32'd0);
        issue(1'b1, 1'b0, 8'h9A);
        chk("R8 data unchanged", {24'd0, d64}, 32'hC3);

        // R7 R3: sequential read across the wrap, pointer fed back
        walk = 8'h9E;
        for (int j = 0; j < 4; j++) begin
            logic [7:0] exp_d;
            issue(1'b1, 1'b0, walk);
            case (j)
                0: exp_d = 8'h78;
                1: exp_d = 8'h90;
                2: exp_d = 8'h11;
                default: exp_d = 8'h22;
            endcase
            chk("R7 sequential data", {24'd0, d64}, {24'd0, exp_d});
            walk = n64;
        end
        chk("R7 sequential end", {24'd0, walk}, 32'h82);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule